// File: doc/BRIEF.md
# Skewed Minimum-SAD Comparison Chain

This block keeps the running best match of a motion search. A row of N SAD engines works on the same current macroblock, with each engine looking at a different reference position. Engine k runs exactly one clock cycle behind engine k-1. A linear chain of N comparison stages mirrors that row, with one stage per engine. A token for one of the 41 partitions enters the head of the chain. It picks up the stored best SAD and motion vector for that partition from a result register file. At stage k the token meets the SAD that engine k delivers for the same partition. If that SAD is strictly smaller, the token takes it and its vector with it. The last stage writes the surviving minimum back into the register file.

There are fewer engines than search positions, so the same partition passes through the chain once per pass. Each pass starts from the minimum that the previous pass wrote back. A clear input returns every entry to the worst possible SAD before a new search. A results-valid flag reports that the token marked as the last one has been written. A combinational read port gives the final minima to the consumer.

Top module: `msad_chain`

## Requirements
- R1: A stage replaces the carried SAD and vector only when its engine is valid and the engine SAD is strictly smaller. On equal SADs the value already carried wins, whether it came from an earlier engine or from an earlier pass.
- R2: A stage whose engine valid bit is low forwards the carried SAD and vector unchanged. Engine data offered while no token is at that stage changes no register-file entry.
- R3: A token entering the head in cycle t is compared with engine k's inputs sampled in cycle t+k. Engine k uses SAD bits [16k+15:16k], x bits [5k+4:5k] and y bits [5k+4:5k].
- R4: The head reads entry head_part as the starting minimum. The result is written back at the end of cycle t+N-1 and can be read from cycle t+N, so results accumulate across passes. A partition must not re-enter sooner than N cycles after its previous entry.
- R5: Clear sets all 41 SADs to 16'hFFFF and all vectors to zero. It discards tokens in flight and drops results_valid. When clear and a write-back fall in the same cycle, clear wins.
- R6: A token entered with head_last=1 in cycle t makes results_valid high from cycle t+N. The flag stays high until clear.
- R7: After reset the register file and results_valid are in the cleared state of R5.
- R8: rd_sad, rd_mvx and rd_mvy show entry rd_part in the same cycle. Motion vectors are 5-bit two's complement values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Re-initialise all minima, flush the chain |
| head_valid | input | 1 | A partition token enters stage 0 this cycle |
| head_part | input | 6 | Partition index 0..40 of the entering token |
| head_last | input | 1 | Marks the final token of the search |
| eng_valid | input | N | Per-engine SAD valid |
| eng_sad | input | 16*N | Per-engine SAD, engine k at bits 16k+ |
| eng_mvx | input | 5*N | Per-engine signed x offset |
| eng_mvy | input | 5*N | Per-engine signed y offset |
| rd_part | input | 6 | Read index |
| rd_sad | output | 16 | Stored minimum SAD of rd_part |
| rd_mvx | output | 5 | Stored x offset of rd_part |
| rd_mvy | output | 5 | Stored y offset of rd_part |
| results_valid | output | 1 | Last token has been written back |

## Verification
The two functions that can land in the same cycle are the last stage's write-back and a clear. The bench starts a token marked last and raises clear in exactly the cycle when that token sits in the final stage. It then expects the entry to read 16'hFFFF with a zero vector and results_valid to stay low. A second collision puts a token in flight and clears the chain under it. The bench then confirms that nothing from that token reaches the register file.

// File: rtl/msad_pkg.sv
package msad_pkg;
    localparam int SAD_W  = 16;
    localparam int MV_W   = 5;
    localparam int NPART  = 41;
    localparam int PIDX_W = $clog2(NPART);

    typedef struct packed {
        logic signed [MV_W-1:0] x;
        logic signed [MV_W-1:0] y;
    } mv_t;

    // One partition travelling down the chain with its best-so-far match
    typedef struct packed {
        logic              vld;
        logic              last;
        logic [PIDX_W-1:0] part;
        logic [SAD_W-1:0]  sad;
        mv_t               mv;
    } tok_t;

    typedef struct packed {
        logic [SAD_W-1:0] sad;
        mv_t              mv;
    } ent_t;
endpackage

// File: rtl/msad_stage.sv
module msad_stage
    import msad_pkg::*;
(
    input  tok_t             up,
    input  logic             eng_vld,
    input  logic [SAD_W-1:0] eng_sad,
    input  mv_t              eng_mv,
    output tok_t             dn
);
    // Strict less-than: the carried (earlier) candidate survives ties
    always_comb begin
        dn = up;
        if (up.vld && eng_vld && (eng_sad < up.sad)) begin
            dn.sad = eng_sad;
            dn.mv  = eng_mv;
        end
    end
endmodule

// File: rtl/msad_rf.sv
module msad_rf
    import msad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_part,
    input  ent_t              wr_ent,
    input  logic [PIDX_W-1:0] ra_part,
    output ent_t              ra_ent,
    input  logic [PIDX_W-1:0] rb_part,
    output ent_t              rb_ent
);
    localparam ent_t INIT_ENT = '{sad: '1, mv: '0};
    localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(NPART);

    ent_t mem_d [NPART];
    ent_t mem_q [NPART];

    always_comb begin
        mem_d = mem_q;
        if (clear) begin
            for (int i = 0; i < NPART; i++) mem_d[i] = INIT_ENT;
        end else if (wr_en && (wr_part < LIMIT)) begin
            mem_d[wr_part] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPART; i++) mem_q[i] <= INIT_ENT;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ra_ent = (ra_part < LIMIT) ? mem_q[ra_part] : INIT_ENT;
    assign rb_ent = (rb_part < LIMIT) ? mem_q[rb_part] : INIT_ENT;

    // R5: clear beats a write-back landing in the same cycle
    a_r5_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && wr_en && (wr_part < LIMIT)) |=> (mem_q[$past(wr_part)].sad == '1));

    // R4: a write-back lands in the addressed entry one edge later
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && wr_en && (wr_part < LIMIT)) |=> (mem_q[$past(wr_part)] == $past(wr_ent)));
endmodule

// File: rtl/msad_chain.sv
module msad_chain
    import msad_pkg::*;
#(
    parameter int N_STAGES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      head_valid,
    input  logic [PIDX_W-1:0]         head_part,
    input  logic                      head_last,
    input  logic [N_STAGES-1:0]       eng_valid,
    input  logic [N_STAGES*SAD_W-1:0] eng_sad,
    input  logic [N_STAGES*MV_W-1:0]  eng_mvx,
    input  logic [N_STAGES*MV_W-1:0]  eng_mvy,
    input  logic [PIDX_W-1:0]         rd_part,
    output logic [SAD_W-1:0]          rd_sad,
    output logic [MV_W-1:0]           rd_mvx,
    output logic [MV_W-1:0]           rd_mvy,
    output logic                      results_valid
);
    localparam int NPIPE = N_STAGES - 1;
    localparam logic [PIDX_W-1:0] LIMIT = PIDX_W'(NPART);

    typedef struct packed {
        tok_t [NPIPE-1:0] pipe;
        logic             done;
    } state_t;

    state_t s_d, s_q;
    tok_t   st_in  [N_STAGES];
    tok_t   st_out [N_STAGES];
    mv_t    eng_mv [N_STAGES];
    tok_t   head_tok, fin;
    ent_t   head_ent, rd_ent, wr_ent;

    always_comb begin
        head_tok.vld  = head_valid && (head_part < LIMIT);
        head_tok.last = head_last;
        head_tok.part = head_part;
        head_tok.sad  = head_ent.sad;
        head_tok.mv   = head_ent.mv;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign st_in[k] = head_tok;
        end else begin : g_link
            assign st_in[k] = s_q.pipe[k-1];
        end
        assign eng_mv[k].x = eng_mvx[k*MV_W +: MV_W];
        assign eng_mv[k].y = eng_mvy[k*MV_W +: MV_W];

        msad_stage u_stage (
            .up      (st_in[k]),
            .eng_vld (eng_valid[k]),
            .eng_sad (eng_sad[k*SAD_W +: SAD_W]),
            .eng_mv  (eng_mv[k]),
            .dn      (st_out[k])
        );

        // R1: a stage never lets the carried minimum grow
        a_r1_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
            st_out[k].vld |-> (st_out[k].sad <= st_in[k].sad));

        // R2: an idle engine leaves the token untouched
        a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (st_in[k].vld && !eng_valid[k]) |->
                (st_out[k].sad == st_in[k].sad && st_out[k].mv == st_in[k].mv));
    end

    assign fin = st_out[N_STAGES-1];

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NPIPE; k++) begin
            s_d.pipe[k] = st_out[k];
            if (clear) s_d.pipe[k].vld = 1'b0;
        end
        if (clear) begin
            s_d.done = 1'b0;
        end else if (fin.vld && fin.last) begin
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ent.sad = fin.sad;
    assign wr_ent.mv  = fin.mv;

    msad_rf u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (fin.vld),
        .wr_part (fin.part),
        .wr_ent  (wr_ent),
        .ra_part (head_part),
        .ra_ent  (head_ent),
        .rb_part (rd_part),
        .rb_ent  (rd_ent)
    );

    assign rd_sad        = rd_ent.sad;
    assign rd_mvx        = rd_ent.mv.x;
    assign rd_mvy        = rd_ent.mv.y;
    assign results_valid = s_q.done;

    // R3: an accepted head token sits in the first skew register next cycle
    a_r3_skew_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && (head_part < LIMIT) && !clear) |=>
            (s_q.pipe[0].vld && s_q.pipe[0].part == $past(head_part)));

    // R5: clear always drops the results flag
    a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !results_valid);

    // R6: the flag rises only after the last token left the final stage
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(results_valid) |-> $past(fin.vld && fin.last && !clear));
endmodule

// File: tb/msad_chain_tb_top.sv
`timescale 1ns/1ps
module msad_chain_tb_top;
    import msad_pkg::*;

    localparam int NS = 4;
    localparam int NT = 8;

    typedef struct packed {
        logic [5:0]        part;
        logic [3:0]        mask;
        logic [15:0]       s0, s1, s2, s3;
        logic [15:0]       exp_sad;
        logic signed [3:0] win;
    } vec_t;

    // mask bit k enables engine k; win = winning engine, -1 means initial entry
    localparam vec_t VEC [NT] = '{
        '{6'd0,  4'hF, 16'd100,   16'd50,    16'd70,    16'd60,    16'd50,    4'sd1},
        '{6'd1,  4'hF, 16'd30,    16'd30,    16'd30,    16'd30,    16'd30,    4'sd0},
        '{6'd2,  4'hF, 16'd9,     16'd8,     16'd7,     16'd6,     16'd6,     4'sd3},
        '{6'd40, 4'hE, 16'd1,     16'd20,    16'd10,    16'd10,    16'd10,    4'sd2},
        '{6'd5,  4'h0, 16'd1,     16'd1,     16'd1,     16'd1,     16'hFFFF,  -4'sd1},
        '{6'd7,  4'hF, 16'hFFFF,  16'hFFFF,  16'hFFFF,  16'hFFFF,  16'hFFFF,  -4'sd1},
        '{6'd20, 4'hF, 16'd0,     16'd5,     16'd0,     16'd0,     16'd0,     4'sd0},
        '{6'd33, 4'h5, 16'd500,   16'd1,     16'd400,   16'd1,     16'd400,   4'sd2}
    };

    logic                clk, rst_n, clear, head_valid, head_last, results_valid;
    logic [5:0]          head_part, rd_part;
    logic [NS-1:0]       eng_valid;
    logic [NS*16-1:0]    eng_sad;
    logic [NS*5-1:0]     eng_mvx, eng_mvy;
    logic [15:0]         rd_sad;
    logic [4:0]          rd_mvx, rd_mvy;

    int n_cmp = 0;
    int n_bad = 0;

    logic [5:0]  s_part [16];
    logic        s_last [16];
    logic [3:0]  s_mask [16];
    logic [15:0] s_sad  [16][NS];

    msad_chain #(.N_STAGES(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .head_valid(head_valid), .head_part(head_part), .head_last(head_last),
        .eng_valid(eng_valid), .eng_sad(eng_sad), .eng_mvx(eng_mvx), .eng_mvy(eng_mvy),
        .rd_part(rd_part), .rd_sad(rd_sad), .rd_mvx(rd_mvx), .rd_mvy(rd_mvy),
        .results_valid(results_valid)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic int mvx_of(int k);
        return k - 2;
    endfunction
    function automatic int mvy_of(int k);
        return 3 - 2 * k;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(string req, int part, int exp_sad, int win);
        rd_part = 6'(part);
        #1;
        chk(req, $sformatf("sad[%0d]", part), int'(rd_sad), exp_sad);
        chk(req, $sformatf("mvx[%0d]", part), int'($signed(rd_mvx)), (win < 0) ? 0 : mvx_of(win));
        chk(req, $sformatf("mvy[%0d]", part), int'($signed(rd_mvy)), (win < 0) ? 0 : mvy_of(win));
    endtask

    // Engine k shows token c-k in cycle c (one-cycle skew per stage)
    task automatic run_stream(input int n, input int clr_at, output logic rv_last, output logic rv_after);
        for (int c = 0; c < n + NS - 1; c++) begin
            @(negedge clk);
            clear      = (c == clr_at);
            head_valid = (c < n);
            head_last  = (c < n) ? s_last[c] : 1'b0;
            head_part  = (c < n) ? s_part[c] : 6'd0;
            for (int k = 0; k < NS; k++) begin
                int idx;
                idx = c - k;
                if (idx >= 0 && idx < n) begin
                    eng_valid[k]       = s_mask[idx][k];
                    eng_sad[k*16 +: 16] = s_sad[idx][k];
                end else begin
                    eng_valid[k]       = 1'b0;
                    eng_sad[k*16 +: 16] = 16'd0;
                end
                eng_mvx[k*5 +: 5] = 5'(mvx_of(k));
                eng_mvy[k*5 +: 5] = 5'(mvy_of(k));
            end
            #1 rv_last = results_valid;
        end
        @(negedge clk);
        clear = 1'b0; head_valid = 1'b0; head_last = 1'b0; eng_valid = '0;
        #1 rv_after = results_valid;
    endtask

    task automatic set_tok(int i, int part, logic last, logic [3:0] mask,
                           int a, int b, int c, int d);
        s_part[i] = 6'(part); s_last[i] = last; s_mask[i] = mask;
        s_sad[i][0] = 16'(a); s_sad[i][1] = 16'(b); s_sad[i][2] = 16'(c); s_sad[i][3] = 16'(d);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic rvl, rva;
        rst_n = 1'b0; clear = 1'b0; head_valid = 1'b0; head_last = 1'b0; head_part = '0;
        eng_valid = '0; eng_sad = '0; eng_mvx = '0; eng_mvy = '0; rd_part = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        chk("R7", "results_valid", int'(results_valid), 0);
        chk_entry("R7", 0, 65535, -1);
        chk_entry("R7", 40, 65535, -1);

        // Table walk: R1 R2 R3 R8, tokens streamed back to back
        for (int i = 0; i < NT; i++)
            set_tok(i, int'(VEC[i].part), 1'b0, VEC[i].mask,
                    int'(VEC[i].s0), int'(VEC[i].s1), int'(VEC[i].s2), int'(VEC[i].s3));
        run_stream(NT, -1, rvl, rva);
        for (int i = 0; i < NT; i++)
            chk_entry("R1", int'(VEC[i].part), int'(VEC[i].exp_sad), int'(VEC[i].win));
        chk("R6", "flag without last token", int'(rva), 0);

        // R3/R2: stray engine data with no token at any stage changes nothing
        @(negedge clk);
        eng_valid = '1; eng_sad = '0;
        repeat (6) @(negedge clk);
        eng_valid = '0;
        chk_entry("R3", 0, 50, 1);
        chk_entry("R2", 33, 400, 2);

        // R4: second pass accumulates; R1 tie against earlier pass keeps it
        set_tok(0, 1, 1'b0, 4'hF, 40, 29, 29, 50);
        set_tok(1, 2, 1'b1, 4'hF, 6, 6, 6, 6);
        run_stream(2, -1, rvl, rva);
        chk_entry("R4", 1, 29, 1);
        chk_entry("R1", 2, 6, 3);
        chk("R6", "flag in final-stage cycle", int'(rvl), 0);
        chk("R6", "flag after write-back", int'(rva), 1);
        repeat (3) @(negedge clk);
        chk("R6", "flag holds", int'(results_valid), 1);

        // R5: clear collides with the final-stage write-back of a last token
        set_tok(0, 3, 1'b1, 4'h1, 10, 0, 0, 0);
        run_stream(1, NS - 1, rvl, rva);
        chk_entry("R5", 3, 65535, -1);
        chk_entry("R5", 1, 65535, -1);
        chk("R5", "flag after clear", int'(rva), 0);

        // R5: clear while a token is in flight discards it
        set_tok(0, 4, 1'b0, 4'h1, 7, 0, 0, 0);
        run_stream(1, 1, rvl, rva);
        chk_entry("R5", 4, 65535, -1);

        // R3: only engine 2 valid, seen two cycles after head
        set_tok(0, 4, 1'b0, 4'h4, 1, 1, 7, 1);
        run_stream(1, -1, rvl, rva);
        chk_entry("R3", 4, 7, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule